// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block is a synthesizable model of a small serial EEPROM that answers a host over three wires: a select line, a serial clock and a data input, plus a data output that can float. It holds a 256 x 8 array by default, or 128 x 16 when the wide-word parameter is set. The serial pins are brought into the system clock domain through a synchronizer, and rising edges of the serial clock are detected there.

A transaction opens with a start bit: the first rising serial-clock edge at which data in is high. A two-bit opcode and an address field follow, and write-type instructions add a data field. Seven instructions are decoded: read, word write, word erase, write-enable, write-disable, erase-all and write-all. Programming instructions take effect only while the write-enable latch is set. They then run a self-timed program cycle that is counted in system clocks and keeps running when select drops. If the host later raises select, the data line reports busy (low) or ready (high).

Top module: `mw_eeprom`

## Requirements
- R1: While select is low, data out is not driven (enable low), and a partly received instruction is discarded without effect. Data out is also undriven after reset.
- R2: With select high and data in low, any number of serial clock rises leaves the block idle. The first rise with data in high is taken as the start bit.
- R3: Field order after the start bit is opcode (2 bits), address (a don't-care bit, then the address MSB first), then data MSB first, all sampled on rising serial clock edges. For a read, data out is driven 0 after the last address bit's rise, and each following rise drives the next data bit, MSB first.
- R4: Opcode 10 reads, 01 writes one word and 11 erases one word. Opcode 00 selects by the two address bits after the don't-care bit: 11 enables writes, 00 disables writes, 10 erases all and 01 writes all.
- R5: A write takes effect only after its full length has been clocked in (20 rises in byte mode, 27 in word mode, start bit included). Short instructions complete at 12 or 11 rises.
- R6: The write-enable latch is clear after reset and after a disable instruction. While it is clear, erase, write, erase-all and write-all change nothing and start no program cycle.
- R7: Erase sets the addressed word to all ones, erase-all sets every word to all ones, and write-all stores the given data in every word.
- R8: A program cycle lasts max(PROG_CYCLES, depth) system clocks and completes whatever select does. Start bits received while it runs are ignored.
- R9: When select is raised after a program cycle was started, data out is driven 0 while busy and 1 once ready. With select low it stays undriven.
- R10: Write-enable and write-disable leave data out undriven.
- R11: After an instruction's required rises, further rises and data in values have no effect until select falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out value |
| sdo_en | output | 1 | Drive enable for serial data out; low means high impedance |

## Verification
The bench builds the byte organization with a program length of 300 system clocks, just above the 256-word depth. This lets the whole-array sweeps of erase-all and write-all finish inside one cycle, while the busy window stays long enough for a complete second instruction to land inside it and be shown to be ignored. The same length makes the busy-to-ready transition on the data line measurable against a cycle window, and keeps every program cycle short enough to run many writes and reads back to back.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_RD, ST_DONE} mw_state_e;

  localparam logic [1:0] OP_GRP = 2'b00;
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_RD  = 2'b10;
  localparam logic [1:0] OP_ER  = 2'b11;

  localparam logic [1:0] GRP_WDIS = 2'b00;
  localparam logic [1:0] GRP_WALL = 2'b01;
  localparam logic [1:0] GRP_EALL = 2'b10;
  localparam logic [1:0] GRP_WEN  = 2'b11;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/mw_ram.sv
module mw_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mw_prog.sv
module mw_prog #(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int PROG_CYCLES = 300
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          bulk,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata
);
  localparam int DEPTH = 1 << AW;
  localparam int LEN   = (PROG_CYCLES < DEPTH) ? DEPTH : PROG_CYCLES;
  localparam int CW    = $clog2(LEN + 1);

  logic [CW-1:0] cnt;
  logic          bulk_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == CW'(LEN - 1)) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (start && !busy) begin
      bulk_q <= bulk;
      addr_q <= addr;
      data_q <= data;
    end
  end

  assign we    = busy && (bulk_q ? (cnt < CW'(DEPTH)) : (cnt == '0));
  assign waddr = bulk_q ? cnt[AW-1:0] : addr_q;
  assign wdata = data_q;

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  // R7
  single_word_once_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !bulk_q) |=> !we);
endmodule

// File: rtl/mw_decode.sv
module mw_decode
  import mw_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          sck_rise,
  input  logic          di,
  input  logic          busy,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] rd_addr,
  output logic          prog_start,
  output logic          prog_bulk,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output logic          do_q,
  output logic          do_en
);
  localparam int HDR = 2 + AW + 1;
  localparam int SRW = HDR + DW;
  localparam int CW  = $clog2(SRW + 1);
  localparam int IW  = (DW > 1) ? $clog2(DW) : 1;

  mw_state_e     state;
  logic [CW-1:0] cnt;
  logic [SRW-1:0] sr;
  logic [IW-1:0] rd_idx;
  logic          cs_d, wen, pending, show;

  logic [SRW-1:0] nsr;
  logic [CW-1:0]  ncnt;
  logic [1:0]     hop, grp, fop;
  logic [AW-1:0]  haddr, faddr;
  logic [DW-1:0]  fdata;
  logic           dc_unused;

  always_comb begin
    nsr   = {sr[SRW-2:0], di};
    ncnt  = cnt + 1'b1;
    hop   = nsr[HDR-1 -: 2];
    haddr = nsr[AW-1:0];
    grp   = nsr[AW-1 -: 2];
    fop   = nsr[SRW-1 -: 2];
    faddr = nsr[DW+AW-1:DW];
    fdata = nsr[DW-1:0];
  end
  assign dc_unused = ^{sr[SRW-1], nsr[AW], nsr[DW+AW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      cs_d       <= 1'b0;
      wen        <= 1'b0;
      pending    <= 1'b0;
      show       <= 1'b0;
      prog_start <= 1'b0;
      do_q       <= 1'b1;
      do_en      <= 1'b0;
    end else begin
      prog_start <= 1'b0;
      cs_d       <= cs;
      if (!cs) begin
        state <= ST_IDLE;
        cnt   <= '0;
        show  <= 1'b0;
        do_en <= 1'b0;
      end else begin
        if (!cs_d && pending) show <= 1'b1;
        case (state)
          ST_IDLE: begin
            do_en <= show;
            do_q  <= ~busy;
            if (sck_rise && di && !busy) begin
              state   <= ST_SHIFT;
              cnt     <= '0;
              show    <= 1'b0;
              pending <= 1'b0;
              do_en   <= 1'b0;
            end
          end
          ST_SHIFT: if (sck_rise) begin
            sr  <= nsr;
            cnt <= ncnt;
            if (ncnt == CW'(HDR)) begin
              case (hop)
                OP_RD: begin
                  state   <= ST_RD;
                  rd_addr <= haddr;
                  rd_idx  <= IW'(DW - 1);
                  do_en   <= 1'b1;
                  do_q    <= 1'b0;
                end
                OP_ER: begin
                  state <= ST_DONE;
                  if (wen) begin
                    prog_start <= 1'b1;
                    pending    <= 1'b1;
                    prog_bulk  <= 1'b0;
                    prog_addr  <= haddr;
                    prog_data  <= '1;
                  end
                end
                OP_GRP: begin
                  case (grp)
                    GRP_WEN:  begin wen <= 1'b1; state <= ST_DONE; end
                    GRP_WDIS: begin wen <= 1'b0; state <= ST_DONE; end
                    GRP_EALL: begin
                      state <= ST_DONE;
                      if (wen) begin
                        prog_start <= 1'b1;
                        pending    <= 1'b1;
                        prog_bulk  <= 1'b1;
                        prog_addr  <= haddr;
                        prog_data  <= '1;
                      end
                    end
                    default: ;
                  endcase
                end
                default: ;
              endcase
            end else if (ncnt == CW'(SRW)) begin
              state <= ST_DONE;
              if (wen) begin
                prog_start <= 1'b1;
                pending    <= 1'b1;
                prog_bulk  <= (fop == OP_GRP);
                prog_addr  <= faddr;
                prog_data  <= fdata;
              end
            end
          end
          ST_RD: if (sck_rise) begin
            do_q <= rdata[rd_idx];
            if (rd_idx == '0) state <= ST_DONE;
            else rd_idx <= rd_idx - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R1
  deselect_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    !cs |=> !do_en);

  // R3
  read_drives_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD) |-> do_en);

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && $past(state) == ST_DONE) |-> ($stable(do_q) && $stable(do_en)));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && state == ST_IDLE) |=> (state == ST_IDLE));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int WORD16      = 0,
  parameter int PROG_CYCLES = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sck,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en
);
  localparam int DW = (WORD16 != 0) ? 16 : 8;
  localparam int AW = (WORD16 != 0) ? 7 : 8;

  logic [2:0]    pins_s;
  logic          cs_s, sck_s, di_s, sck_d, sck_rise;
  logic          busy, we, p_start, p_bulk;
  logic [AW-1:0] waddr, raddr, p_addr;
  logic [DW-1:0] wdata, rdata, p_data;

  mw_sync #(.W(3), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d({cs, sck, sdi}), .q(pins_s)
  );
  assign {cs_s, sck_s, di_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end
  assign sck_rise = sck_s && !sck_d;

  mw_decode #(.AW(AW), .DW(DW)) u_dec (
    .clk(clk), .rst(rst), .cs(cs_s), .sck_rise(sck_rise), .di(di_s),
    .busy(busy), .rdata(rdata), .rd_addr(raddr),
    .prog_start(p_start), .prog_bulk(p_bulk), .prog_addr(p_addr),
    .prog_data(p_data), .do_q(sdo), .do_en(sdo_en)
  );

  mw_prog #(.AW(AW), .DW(DW), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst(rst), .start(p_start), .bulk(p_bulk), .addr(p_addr),
    .data(p_data), .busy(busy), .we(we), .waddr(waddr), .wdata(wdata)
  );

  mw_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
  localparam int PROG = 300;
  localparam logic [15:0] VEC [8] = '{16'h003C, 16'hFFA5, 16'h0100, 16'h80FF,
                                      16'h7F81, 16'h55C3, 16'hAA5A, 16'h1001};

  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en;
  int   n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  mw_eeprom #(.WORD16(0), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst(rst), .cs(cs), .sck(sck), .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b);
    sdi = b; idle(6); sck = 1'b1; idle(6); sck = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
  endtask

  task automatic deselect;
    cs = 1'b0; sdi = 1'b0; idle(8);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                     input bit long_f);
    cs = 1'b1; idle(2);
    clk_bit(1'b1); send(32'(op), 2); send({23'd0, 1'b0, a}, 9);
    if (long_f) send(32'(d), 8);
    deselect;
  endtask

  task automatic rd(input logic [7:0] a, input int pre, output logic [7:0] q,
                    output bit hdr_ok);
    bit quiet = 1'b1;
    cs = 1'b1; idle(2);
    for (int i = 0; i < pre; i++) begin
      clk_bit(1'b0);
      if (sdo_en) quiet = 1'b0;
    end
    if (pre > 0) check(quiet, "R2 idle clocks before start", 1, 0);
    clk_bit(1'b1); send(32'(OP_RD_T), 2); send({23'd0, 1'b0, a}, 9);
    hdr_ok = sdo_en && !sdo;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b0);
      q[i] = sdo;
      if (!sdo_en) hdr_ok = 1'b0;
    end
  endtask
  localparam logic [1:0] OP_RD_T = 2'b10;

  task automatic wait_ready(output int n);
    cs = 1'b1; n = 0; idle(4);
    while (!(sdo_en && sdo) && n < 3000) begin idle(1); n++; end
    check(n < 3000, "R9 ready reported", n, 0);
  endtask

  task automatic read_check(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [7:0] q; bit ok;
    rd(a, 0, q, ok);
    deselect;
    check(ok, "R3 dummy zero and drive", 0, 1);
    check(q == exp, req, q, exp);
  endtask

  task automatic run_all;
    int n; logic [7:0] q; bit ok;
    idle(5);
    check(!sdo_en, "R1 reset leaves output undriven", sdo_en, 0);
    rst = 1'b0; idle(4);

    // R10: write-enable leaves output undriven; R4 group code 11
    cmd(2'b00, 8'hC0, 8'h00, 1'b0);
    cs = 1'b1; idle(10);
    check(!sdo_en, "R10 enable instruction undriven", sdo_en, 0);
    deselect;

    // R7 erase-all (group 10)
    cmd(2'b00, 8'h80, 8'h00, 1'b0);
    wait_ready(n); deselect;
    read_check(8'h00, 8'hFF, "R7 erase-all low word");
    read_check(8'hFF, 8'hFF, "R7 erase-all top word");

    // R10 / R6: write-disable then refused write
    cmd(2'b00, 8'h00, 8'h00, 1'b0);
    cs = 1'b1; idle(10);
    check(!sdo_en, "R10 disable instruction undriven", sdo_en, 0);
    deselect;
    cmd(2'b01, 8'h05, 8'h12, 1'b1);
    cs = 1'b1; idle(10);
    check(!sdo_en, "R6 no program cycle when disabled", sdo_en, 0);
    deselect;
    read_check(8'h05, 8'hFF, "R6 refused write left word");

    cmd(2'b00, 8'hC0, 8'h00, 1'b0);

    // R4 table walk: write then read back
    for (int i = 0; i < 8; i++) begin
      cmd(2'b01, VEC[i][15:8], VEC[i][7:0], 1'b1);
      wait_ready(n); deselect;
      read_check(VEC[i][15:8], VEC[i][7:0], "R4 write then read");
    end

    // R9 busy then ready, R8 duration
    cmd(2'b01, 8'h20, 8'h77, 1'b1);
    cs = 1'b1; idle(8);
    check(sdo_en && !sdo, "R9 busy shown low", {sdo_en, sdo}, 2);
    n = 0;
    while (!(sdo_en && sdo) && n < 3000) begin idle(1); n++; end
    check(n >= 200 && n <= 320, "R8 program length", n, PROG);
    deselect;
    read_check(8'h20, 8'h77, "R4 write after status");

    // R9 select low across the whole cycle
    cmd(2'b01, 8'h21, 8'h66, 1'b1);
    idle(20);
    check(!sdo_en, "R9 undriven while deselected", sdo_en, 0);
    idle(400);
    cs = 1'b1; idle(8);
    check(sdo_en && sdo, "R9 ready high after cycle", {sdo_en, sdo}, 3);
    deselect;
    read_check(8'h21, 8'h66, "R8 cycle completed without select");

    // R8 instruction during busy is ignored
    cmd(2'b01, 8'h30, 8'h11, 1'b1);
    cmd(2'b01, 8'h31, 8'h22, 1'b1);
    wait_ready(n); deselect;
    read_check(8'h31, 8'hFF, "R8 start ignored while busy");
    read_check(8'h30, 8'h11, "R8 first write kept");

    // R7 single-word erase
    cmd(2'b11, 8'h55, 8'h00, 1'b0);
    wait_ready(n); deselect;
    read_check(8'h55, 8'hFF, "R7 erase one word");
    read_check(8'h7F, 8'h81, "R7 neighbour untouched");

    // R5 / R1 aborted write
    cs = 1'b1; idle(2);
    clk_bit(1'b1); send(32'h1, 2); send(32'h001, 9); send(32'hA, 4);
    deselect; idle(400);
    read_check(8'h01, 8'h00, "R5 aborted write no effect");

    // R2 leading idle clocks, R11 trailing clocks ignored
    rd(8'h10, 5, q, ok);
    check(ok && q == 8'h01, "R2 read after idle clocks", q, 8'h01);
    for (int i = 0; i < 12; i++) clk_bit(1'b1);
    check(sdo_en && sdo, "R11 output holds last bit", {sdo_en, sdo}, 3);
    deselect;
    read_check(8'hFF, 8'hA5, "R11 trailing clocks decoded nothing");

    // R7 write-all (group 01)
    cmd(2'b00, 8'h40, 8'h5A, 1'b1);
    wait_ready(n); deselect;
    read_check(8'h00, 8'h5A, "R7 write-all low word");
    read_check(8'hC7, 8'h5A, "R7 write-all other word");
  endtask

  initial begin
    fork
      run_all;
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule